// File: doc/BRIEF.md
# Condition Flag Register with Bitwise Flag Logic

This block keeps the 32-bit condition register of an integer and floating-point core. The register is split into eight 4-bit fields, and each field holds the flags less-than, greater-than, equal and summary-overflow, in that order from the most significant bit. The execute units send in requests that update the register. An integer result can be recorded into field 0. Floating-point summary status can be recorded into field 1. A compare result can be sent to any field. A field can be copied to another field. A conditional-store outcome can be recorded. A general-purpose register value can be written under a per-field mask. One of eight boolean operations can combine any two register bits into a third bit.

Every update takes effect at the next rising clock edge, and all of them read the register value from before that edge. When several requests arrive in the same cycle, a fixed priority decides which one wins. The whole register is always visible on a read port. A single-bit read port, which branch evaluation uses, returns one selected bit combinationally.

Top module: `cr_file`

## Requirements
- R1: After the active-low asynchronous reset, `cr_o` is all zeros.
- R2: CR bit number n (0 is the most significant) is `cr_o[31-n]`. Field f covers bit numbers 4f to 4f+3, ordered LT, GT, EQ, SO. `rd_bit_o` equals `cr_o[31-rd_bit_idx_i]` in the same cycle. Any update shows up only after the next rising edge.
- R3: `int_rec_i` writes field 0 with {result < 0 (signed), result > 0 (signed), result == 0, `so_i`}.
- R4: `fp_rec_i` writes field 1 with `fp_sum_i` unchanged. `fp_sum_i[3:0]` carries FX, FEX, VX and OX, with FX in bit 3.
- R5: `cmp_en_i` writes `cmp_flags_i` (bit 3 = LT down to bit 0 = SO) into the field selected by `cmp_fld_i`, for any of the eight fields.
- R6: `stc_en_i` writes field 0 with {0, 0, `stc_ok_i`, `so_i`}, so the store outcome lands in CR bit 2 (`cr_o[29]`).
- R7: `bop_en_i` sets CR bit `bop_t_i` to op(CR[`bop_a_i`], CR[`bop_b_i`]) and leaves every other bit unchanged. The sources are read before the edge. The codes in `bop_op_i` are: 0 = a&b, 1 = a&~b, 2 = ~(a^b), 3 = ~(a&b), 4 = ~(a|b), 5 = a|b, 6 = a|~b, 7 = a^b.
- R8: `mv_en_i` copies the value that field `mv_src_i` held before the edge into field `mv_dst_i`.
- R9: `gpr_wr_en_i` writes `gpr_data_i[31-4f -: 4]` into field f for every f whose mask bit `gpr_mask_i[7-f]` is 1. Fields with a mask bit of 0 are left unchanged.
- R10: Same-cycle priority, from highest to lowest, is: bit operation, conditional store, integer record, floating-point record, compare, field move, masked write. A lower-priority request still updates the fields or bits that no higher-priority request touches.
- R11: In a cycle with no request, `cr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_rec_i | input | 1 | Record the integer result into field 0 |
| int_res_i | input | 32 | Signed integer result |
| so_i | input | 1 | Summary-overflow copy from the fixed-point exception register |
| fp_rec_i | input | 1 | Record the floating-point summary into field 1 |
| fp_sum_i | input | 4 | Floating-point summary bits FX, FEX, VX, OX |
| cmp_en_i | input | 1 | Compare result is valid |
| cmp_fld_i | input | 3 | Target field of the compare |
| cmp_flags_i | input | 4 | Compare flags LT, GT, EQ, SO |
| stc_en_i | input | 1 | Conditional-store outcome is valid |
| stc_ok_i | input | 1 | Conditional store succeeded |
| mv_en_i | input | 1 | Field-to-field copy |
| mv_src_i | input | 3 | Source field of the copy |
| mv_dst_i | input | 3 | Destination field of the copy |
| gpr_wr_en_i | input | 1 | Masked write from a general-purpose register |
| gpr_mask_i | input | 8 | Field mask, MSB selects field 0 |
| gpr_data_i | input | 32 | Data to write |
| bop_en_i | input | 1 | Bit boolean operation |
| bop_op_i | input | 3 | Operation code |
| bop_a_i | input | 5 | First source bit number |
| bop_b_i | input | 5 | Second source bit number |
| bop_t_i | input | 5 | Target bit number |
| rd_bit_idx_i | input | 5 | Bit number for the single-bit read |
| rd_bit_o | output | 1 | Selected bit |
| cr_o | output | 32 | Whole register |

## Verification
A wrong flag, a field select that picks the wrong field, or a priority slip changes one or more bits of `cr_o` one edge after the request that caused it. The error stays in the register until something overwrites it. A bit operation or a field move that reads the wrong source also shows up one edge later. It can then feed more wrong bits into later operations. A misrouted single-bit read shows up in the same cycle on `rd_bit_o`. For these reasons the whole register and the selected bit are compared with an independent model after every edge.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int FLD_W = 4;

  typedef enum logic [2:0] {
    BOP_AND  = 3'd0,
    BOP_ANDC = 3'd1,
    BOP_EQV  = 3'd2,
    BOP_NAND = 3'd3,
    BOP_NOR  = 3'd4,
    BOP_OR   = 3'd5,
    BOP_ORC  = 3'd6,
    BOP_XOR  = 3'd7
  } bop_e;
endpackage

// File: rtl/cr_bool_op.sv
module cr_bool_op
  import cr_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       a_i,
  input  logic       b_i,
  output logic       y_o
);
  bop_e op;
  assign op = bop_e'(op_i);

  always_comb begin
    unique case (op)
      BOP_AND:  y_o = a_i & b_i;
      BOP_ANDC: y_o = a_i & ~b_i;
      BOP_EQV:  y_o = ~(a_i ^ b_i);
      BOP_NAND: y_o = ~(a_i & b_i);
      BOP_NOR:  y_o = ~(a_i | b_i);
      BOP_OR:   y_o = a_i | b_i;
      BOP_ORC:  y_o = a_i | ~b_i;
      default:  y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/cr_field_sel.sv
module cr_field_sel
  import cr_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_ID   = 0,
  localparam int FID_W     = $clog2(NUM_FIELDS)
) (
  input  logic [FLD_W-1:0]      cur_fld_i,
  input  logic                  gpr_wr_en_i,
  input  logic [NUM_FIELDS-1:0] gpr_mask_i,
  input  logic [FLD_W-1:0]      gpr_fld_i,
  input  logic                  mv_en_i,
  input  logic [FID_W-1:0]      mv_dst_i,
  input  logic [FLD_W-1:0]      mv_src_fld_i,
  input  logic                  cmp_en_i,
  input  logic [FID_W-1:0]      cmp_fld_i,
  input  logic [FLD_W-1:0]      cmp_flags_i,
  input  logic                  fp_rec_i,
  input  logic [FLD_W-1:0]      fp_sum_i,
  input  logic                  int_rec_i,
  input  logic [FLD_W-1:0]      int_flags_i,
  input  logic                  stc_en_i,
  input  logic [FLD_W-1:0]      stc_flags_i,
  output logic [FLD_W-1:0]      nxt_fld_o
);
  localparam bit IS_F0 = (FIELD_ID == 0);
  localparam bit IS_F1 = (FIELD_ID == 1);
  localparam logic [FID_W-1:0] MY_ID = FID_W'(FIELD_ID);

  // later assignments win: lowest priority first
  always_comb begin
    nxt_fld_o = cur_fld_i;
    if (gpr_wr_en_i && gpr_mask_i[NUM_FIELDS-1-FIELD_ID]) nxt_fld_o = gpr_fld_i;
    if (mv_en_i && (mv_dst_i == MY_ID))                    nxt_fld_o = mv_src_fld_i;
    if (cmp_en_i && (cmp_fld_i == MY_ID))                  nxt_fld_o = cmp_flags_i;
    if (IS_F1 && fp_rec_i)                                 nxt_fld_o = fp_sum_i;
    if (IS_F0 && int_rec_i)                                nxt_fld_o = int_flags_i;
    if (IS_F0 && stc_en_i)                                 nxt_fld_o = stc_flags_i;
  end
endmodule

// File: rtl/cr_file.sv
module cr_file
  import cr_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int XLEN       = 32,
  localparam int CR_W      = NUM_FIELDS * FLD_W,
  localparam int FID_W     = $clog2(NUM_FIELDS),
  localparam int IDX_W     = $clog2(CR_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  int_rec_i,
  input  logic [XLEN-1:0]       int_res_i,
  input  logic                  so_i,
  input  logic                  fp_rec_i,
  input  logic [FLD_W-1:0]      fp_sum_i,
  input  logic                  cmp_en_i,
  input  logic [FID_W-1:0]      cmp_fld_i,
  input  logic [FLD_W-1:0]      cmp_flags_i,
  input  logic                  stc_en_i,
  input  logic                  stc_ok_i,
  input  logic                  mv_en_i,
  input  logic [FID_W-1:0]      mv_src_i,
  input  logic [FID_W-1:0]      mv_dst_i,
  input  logic                  gpr_wr_en_i,
  input  logic [NUM_FIELDS-1:0] gpr_mask_i,
  input  logic [CR_W-1:0]       gpr_data_i,
  input  logic                  bop_en_i,
  input  logic [2:0]            bop_op_i,
  input  logic [IDX_W-1:0]      bop_a_i,
  input  logic [IDX_W-1:0]      bop_b_i,
  input  logic [IDX_W-1:0]      bop_t_i,
  input  logic [IDX_W-1:0]      rd_bit_idx_i,
  output logic                  rd_bit_o,
  output logic [CR_W-1:0]       cr_o
);
  localparam logic [IDX_W-1:0] TOP_POS = IDX_W'(CR_W - 1);

  logic [CR_W-1:0]  cr_q, fld_nxt, cr_nxt;
  logic [FLD_W-1:0] fld_q [NUM_FIELDS];
  logic [FLD_W-1:0] int_flags, stc_flags;
  logic             int_lt, int_eq, bop_y;

  assign int_lt    = int_res_i[XLEN-1];
  assign int_eq    = ~|int_res_i;
  assign int_flags = {int_lt, ~int_lt & ~int_eq, int_eq, so_i};
  assign stc_flags = {2'b00, stc_ok_i, so_i};

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    assign fld_q[f] = cr_q[CR_W-1-f*FLD_W -: FLD_W];

    cr_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_ID(f)) u_sel (
      .cur_fld_i   (fld_q[f]),
      .gpr_wr_en_i (gpr_wr_en_i),
      .gpr_mask_i  (gpr_mask_i),
      .gpr_fld_i   (gpr_data_i[CR_W-1-f*FLD_W -: FLD_W]),
      .mv_en_i     (mv_en_i),
      .mv_dst_i    (mv_dst_i),
      .mv_src_fld_i(fld_q[mv_src_i]),
      .cmp_en_i    (cmp_en_i),
      .cmp_fld_i   (cmp_fld_i),
      .cmp_flags_i (cmp_flags_i),
      .fp_rec_i    (fp_rec_i),
      .fp_sum_i    (fp_sum_i),
      .int_rec_i   (int_rec_i),
      .int_flags_i (int_flags),
      .stc_en_i    (stc_en_i),
      .stc_flags_i (stc_flags),
      .nxt_fld_o   (fld_nxt[CR_W-1-f*FLD_W -: FLD_W])
    );
  end

  // bit numbers count from the MSB
  cr_bool_op u_bop (
    .op_i(bop_op_i),
    .a_i (cr_q[TOP_POS - bop_a_i]),
    .b_i (cr_q[TOP_POS - bop_b_i]),
    .y_o (bop_y)
  );

  always_comb begin
    cr_nxt = fld_nxt;
    if (bop_en_i) cr_nxt[TOP_POS - bop_t_i] = bop_y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cr_q <= '0;
    else         cr_q <= cr_nxt;
  end

  assign cr_o     = cr_q;
  assign rd_bit_o = cr_q[TOP_POS - rd_bit_idx_i];

  logic any_req;
  assign any_req = int_rec_i | fp_rec_i | cmp_en_i | stc_en_i | mv_en_i | gpr_wr_en_i | bop_en_i;

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req |=> $stable(cr_o));

  // R9
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpr_wr_en_i && (&gpr_mask_i) && !(int_rec_i | fp_rec_i | cmp_en_i | stc_en_i | mv_en_i | bop_en_i))
    |=> cr_o == $past(gpr_data_i));

  // R7
  bop_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bop_en_i && !(int_rec_i | fp_rec_i | cmp_en_i | stc_en_i | mv_en_i | gpr_wr_en_i))
    |=> ((cr_o ^ $past(cr_o)) & ~({1'b1, {(CR_W-1){1'b0}}} >> $past(bop_t_i))) == '0);

  // R3
  int_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rec_i && !stc_en_i && !(bop_en_i && (bop_t_i < IDX_W'(FLD_W))))
    |=> cr_o[CR_W-1 -: FLD_W] == {($signed($past(int_res_i)) < 0), ($signed($past(int_res_i)) > 0),
                                  ($past(int_res_i) == '0), $past(so_i)});

  // R8
  move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_en_i && !(int_rec_i | fp_rec_i | cmp_en_i | stc_en_i | gpr_wr_en_i | bop_en_i))
    |=> fld_q[$past(mv_dst_i)] == $past(fld_q[mv_src_i]));
endmodule

// File: tb/cr_file_bench.sv
module cr_file_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        int_rec_i, so_i, fp_rec_i, cmp_en_i, stc_en_i, stc_ok_i, mv_en_i, gpr_wr_en_i, bop_en_i;
  logic [31:0] int_res_i, gpr_data_i, cr_o;
  logic [3:0]  fp_sum_i, cmp_flags_i;
  logic [2:0]  cmp_fld_i, mv_src_i, mv_dst_i, bop_op_i;
  logic [7:0]  gpr_mask_i;
  logic [4:0]  bop_a_i, bop_b_i, bop_t_i, rd_bit_idx_i;
  logic        rd_bit_o;

  int tests = 0, fails = 0;
  bit m [32];

  always #5 clk_i = ~clk_i;

  cr_file u_cr_file (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_vec();
    logic [31:0] v;
    for (int n = 0; n < 32; n++) v[31-n] = m[n];
    return v;
  endfunction

  task automatic clear_in();
    {int_rec_i, so_i, fp_rec_i, cmp_en_i, stc_en_i, stc_ok_i, mv_en_i, gpr_wr_en_i, bop_en_i} = '0;
    int_res_i = '0; gpr_data_i = '0; fp_sum_i = '0; cmp_flags_i = '0; cmp_fld_i = '0;
    mv_src_i = '0; mv_dst_i = '0; bop_op_i = '0; gpr_mask_i = '0;
    bop_a_i = '0; bop_b_i = '0; bop_t_i = '0;
  endtask

  function automatic bit eval_op(int op, bit a, bit b);
    case (op)
      0: return a && b;
      1: return a && !b;
      2: return a == b;
      3: return !(a && b);
      4: return !(a || b);
      5: return a || b;
      6: return a || !b;
      default: return a != b;
    endcase
  endfunction

  // apply requests in ascending priority onto a copy of the old state
  task automatic model_step();
    bit nx [32];
    bit [3:0] fv;
    int sr;
    nx = m;
    if (gpr_wr_en_i)
      for (int n = 0; n < 32; n++) if (gpr_mask_i[7 - n/4]) nx[n] = gpr_data_i[31-n];
    if (mv_en_i)
      for (int k = 0; k < 4; k++) nx[mv_dst_i*4 + k] = m[mv_src_i*4 + k];
    if (cmp_en_i)
      for (int k = 0; k < 4; k++) nx[cmp_fld_i*4 + k] = cmp_flags_i[3-k];
    if (fp_rec_i)
      for (int k = 0; k < 4; k++) nx[4 + k] = fp_sum_i[3-k];
    if (int_rec_i) begin
      sr = int_res_i;
      fv = {sr < 0, sr > 0, sr == 0, so_i};
      for (int k = 0; k < 4; k++) nx[k] = fv[3-k];
    end
    if (stc_en_i) begin
      fv = {1'b0, 1'b0, stc_ok_i, so_i};
      for (int k = 0; k < 4; k++) nx[k] = fv[3-k];
    end
    if (bop_en_i) nx[bop_t_i] = eval_op(int'(bop_op_i), m[bop_a_i], m[bop_b_i]);
    m = nx;
  endtask

  // inputs already set at a negedge; check read port, clock, compare
  task automatic step(string tag);
    #1;
    chk("R2 pre-edge bit read", {31'b0, rd_bit_o}, {31'b0, m[rd_bit_idx_i]});
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk(tag, cr_o, model_vec());
    clear_in();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_in();
    rd_bit_idx_i = '0;
    for (int n = 0; n < 32; n++) m[n] = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset value", cr_o, 32'h0);

    gpr_wr_en_i = 1; gpr_mask_i = 8'hFF; gpr_data_i = 32'hA5C3_1E7F; step("R9 full write");
    gpr_wr_en_i = 1; gpr_mask_i = 8'h81; gpr_data_i = 32'hFFFF_FFFF; step("R9 masked write");
    chk("R9 masked result", cr_o, 32'hF5C3_1E7F);

    int_rec_i = 1; int_res_i = 32'hFFFF_FFF0; so_i = 1; step("R3 negative");
    chk("R3 negative field", {28'b0, cr_o[31:28]}, 32'h9);
    int_rec_i = 1; int_res_i = 32'd77; step("R3 positive");
    int_rec_i = 1; int_res_i = 32'd0; step("R3 zero");
    chk("R3 zero field", {28'b0, cr_o[31:28]}, 32'h2);

    fp_rec_i = 1; fp_sum_i = 4'b1010; step("R4 fp record");
    chk("R4 field1", {28'b0, cr_o[27:24]}, 32'hA);

    cmp_en_i = 1; cmp_fld_i = 3'd7; cmp_flags_i = 4'b0100; step("R5 cmp field7");
    cmp_en_i = 1; cmp_fld_i = 3'd3; cmp_flags_i = 4'b1001; step("R5 cmp field3");

    stc_en_i = 1; stc_ok_i = 1; so_i = 0; step("R6 store ok");
    chk("R6 bit2", {31'b0, cr_o[29]}, 32'h1);
    stc_en_i = 1; stc_ok_i = 0; so_i = 1; step("R6 store fail");

    for (int op = 0; op < 8; op++) begin
      for (int pat = 0; pat < 4; pat++) begin
        gpr_wr_en_i = 1; gpr_mask_i = 8'hFF;
        gpr_data_i = {pat[1], 29'h0AAA_5555, pat[0], 2'b01};
        step("R9 setup");
        bop_en_i = 1; bop_op_i = 3'(op); bop_a_i = 5'd0; bop_b_i = 5'd29; bop_t_i = 5'(op*3 + 4);
        step("R7 bit op");
      end
    end

    gpr_wr_en_i = 1; gpr_mask_i = 8'hFF; gpr_data_i = 32'h1234_5678; step("R9 setup");
    mv_en_i = 1; mv_src_i = 3'd6; mv_dst_i = 3'd1; step("R8 move");
    chk("R8 moved field", {28'b0, cr_o[27:24]}, 32'h7);

    step("R11 idle");
    step("R11 idle again");

    gpr_wr_en_i = 1; gpr_mask_i = 8'hFF; gpr_data_i = 32'hFFFF_FFFF;
    int_rec_i = 1; int_res_i = 32'd5; so_i = 0;
    bop_en_i = 1; bop_op_i = 3'd7; bop_a_i = 5'd0; bop_b_i = 5'd0; bop_t_i = 5'd1;
    step("R10 mixed priority");
    chk("R10 field0", {28'b0, cr_o[31:28]}, 32'h0);
    stc_en_i = 1; stc_ok_i = 1; int_rec_i = 1; int_res_i = 32'hFFFF_FFFF; cmp_en_i = 1; cmp_fld_i = 0;
    cmp_flags_i = 4'hF; step("R10 store over record");
    fp_rec_i = 1; fp_sum_i = 4'h3; cmp_en_i = 1; cmp_fld_i = 1; cmp_flags_i = 4'hC;
    mv_en_i = 1; mv_src_i = 3'd2; mv_dst_i = 3'd1; step("R10 fp over cmp");

    for (int n = 0; n < 32; n++) begin
      rd_bit_idx_i = 5'(n);
      #1;
      chk("R2 bit read", {31'b0, rd_bit_o}, {31'b0, cr_o[31-n]});
    end

    for (int i = 0; i < 400; i++) begin
      int_rec_i = ($urandom_range(0, 3) == 0); int_res_i = $urandom(); so_i = 1'($urandom());
      fp_rec_i = ($urandom_range(0, 3) == 0); fp_sum_i = 4'($urandom());
      cmp_en_i = ($urandom_range(0, 3) == 0); cmp_fld_i = 3'($urandom()); cmp_flags_i = 4'($urandom());
      stc_en_i = ($urandom_range(0, 5) == 0); stc_ok_i = 1'($urandom());
      mv_en_i = ($urandom_range(0, 3) == 0); mv_src_i = 3'($urandom()); mv_dst_i = 3'($urandom());
      gpr_wr_en_i = ($urandom_range(0, 3) == 0); gpr_mask_i = 8'($urandom()); gpr_data_i = $urandom();
      bop_en_i = ($urandom_range(0, 2) == 0); bop_op_i = 3'($urandom());
      bop_a_i = 5'($urandom()); bop_b_i = 5'($urandom()); bop_t_i = 5'($urandom());
      rd_bit_idx_i = 5'($urandom());
      step("R10 random mix");
    end

    rst_ni = 1'b0;
    #1;
    for (int n = 0; n < 32; n++) m[n] = 1'b0;
    chk("R1 async reset", cr_o, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule